// File: doc/BRIEF.md
# Watchdog Reload Timer

This block is a system-management watchdog that sits behind a 32-byte, byte-addressed register window. A down counter loses one count on every tick strobe from an external prescaler; each tick is meant to stand for 0.6 s of wall time. Software keeps the system alive by writing the reload register often enough. When the count runs out, the first expiry only raises a timeout flag and restarts the count. A second expiry while that flag is still set asks for a system reset, unless a no-reboot gate is set.

The host reaches the block through one synchronous port: an address, a write strobe with 16-bit data, and a read strobe whose data returns one cycle later. The counter leaves reset halted with the no-reboot gate closed, so nothing happens until software starts it on purpose.

Register offsets: 0x00 reload/current count, 0x04 first status, 0x06 second status, 0x08 first control, 0x0A second control, 0x12 initial value. All accesses are 16-bit.

Top module: `sysmgmt_wdog`

## Requirements
- R1: After reset, the count and the initial value are 4, the halt bit is 1, the no-reboot gate is 1, and every status bit, `timeout_sts` and `reset_req` are 0.
- R2: Any write to offset 0x00 loads the count from the initial value, whatever the data. A read of 0x00 returns the count in bits [9:0], with bits [15:10] reading 0.
- R3: Bit 11 of the first control register (0x08) is the halt bit and reads back as written; the other bits read 0. While it is 1, ticks leave the count unchanged. While it is 0, each tick lowers the count by one.
- R4: The initial-value register (0x12) holds the reload value in bits [9:0]. A write whose low field is 0 to 3 leaves that field unchanged, and 4 is accepted. Bits [15:10] always take the written data and read back as written.
- R5: A tick that finds the count at 1 while running is an expiry. The count reloads from the initial value instead of reaching 0. If bit 3 of the first status register (0x04) is clear, the expiry sets it, and `timeout_sts` follows that bit.
- R6: An expiry while status bit 3 is already set sets bit 1 of the second status register (0x06). If the no-reboot gate is 0, it also sets bit 0 of that register and drives `reset_req` high for exactly one cycle, starting the cycle after the expiring tick.
- R7: Bit 0 of the second control register (0x0A) is the no-reboot gate and reads back as written. While it is 1, an expiry never asserts `reset_req`.
- R8: Status bit 3 at 0x04 and bits [1:0] at 0x06 are write-1-to-clear: a 1 in a data bit clears the matching status bit and a 0 leaves it alone. Writing 0x0003 to 0x06 clears both of its bits.
- R9: Read data appears on `rd_data` on the clock edge where `rd_en` is sampled high. Offsets outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte offset of the access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, registered |
| tick_en | input | 1 | Prescaled count strobe |
| timeout_sts | output | 1 | First-expiry status flag |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count shows up on the next read of offset 0x00. Within one initial-value period it also shows up as an expiry that comes early or late, visible on `timeout_sts` in the cycle after the expiring tick. A stuck timeout flag or a broken no-reboot gate only becomes visible one period later, as a `reset_req` pulse that appears or fails to appear, so the bench drives two full periods after each change to the gate. A filter that lets a low initial value through is caught by reading the initial-value register straight after the write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int OFF_RELOAD = 'h00;
   localparam int OFF_STAT1  = 'h04;
   localparam int OFF_STAT2  = 'h06;
   localparam int OFF_CTRL1  = 'h08;
   localparam int OFF_CTRL2  = 'h0A;
   localparam int OFF_INIT   = 'h12;

   localparam int STAT2_W    = 2;

   typedef struct packed {
      logic reload;
      logic stat1;
      logic stat2;
      logic ctrl1;
      logic ctrl2;
      logic init;
   } wdog_sel_t;

endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output wdog_sel_t         sel
);

   always_comb begin
      sel        = '0;
      sel.reload = (addr == ADDR_W'(OFF_RELOAD));
      sel.stat1  = (addr == ADDR_W'(OFF_STAT1));
      sel.stat2  = (addr == ADDR_W'(OFF_STAT2));
      sel.ctrl1  = (addr == ADDR_W'(OFF_CTRL1));
      sel.ctrl2  = (addr == ADDR_W'(OFF_CTRL2));
      sel.init   = (addr == ADDR_W'(OFF_INIT));
   end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int CNT_W    = 10,
   parameter int MIN_INIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             halt,
   input  logic             reload,
   input  logic [CNT_W-1:0] init_val,
   input  logic             timeout_q,
   input  logic             no_reboot,
   output logic [CNT_W-1:0] count,
   output logic             expire_first,
   output logic             expire_again,
   output logic             reset_req
);

   logic             step;
   logic             expire;
   logic [CNT_W-1:0] count_q;
   logic             req_q;

   assign step         = tick_en && !halt && !reload;
   assign expire       = step && (count_q == CNT_W'(1));
   assign expire_first = expire && !timeout_q;
   assign expire_again = expire && timeout_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= CNT_W'(MIN_INIT);
      end else if (reload || expire) begin
         count_q <= init_val;
      end else if (step) begin
         count_q <= count_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else begin
         req_q <= expire_again && !no_reboot;
      end
   end

   assign count     = count_q;
   assign reset_req = req_q;

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 10,
   parameter int MIN_INIT = 4,
   parameter int HALT_BIT = 11,
   parameter int TO_BIT   = 3,
   parameter int NRB_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wdog_sel_t         sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [CNT_W-1:0]  count,
   input  logic              expire_first,
   input  logic              expire_again,
   output logic              halt,
   output logic              no_reboot,
   output logic              timeout_q,
   output logic [CNT_W-1:0]  init_val,
   output logic [DATA_W-1:0] rd_data
);

   localparam int HI_W = DATA_W - CNT_W;

   logic                halt_q;
   logic                nrb_q;
   logic                to_q;
   logic [CNT_W-1:0]    init_lo_q;
   logic [HI_W-1:0]     init_hi_q;
   logic [STAT2_W-1:0]  stat2_q;
   logic [STAT2_W-1:0]  stat2_set;
   logic [DATA_W-1:0]   rd_mux;
   logic [DATA_W-1:0]   rd_q;
   logic                init_ok;

   assign init_ok = (wr_data[CNT_W-1:0] >= CNT_W'(MIN_INIT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_q <= 1'b1;
      end else if (wr_en && sel.ctrl1) begin
         halt_q <= wr_data[HALT_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nrb_q <= 1'b1;
      end else if (wr_en && sel.ctrl2) begin
         nrb_q <= wr_data[NRB_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_lo_q <= CNT_W'(MIN_INIT);
         init_hi_q <= '0;
      end else if (wr_en && sel.init) begin
         init_hi_q <= wr_data[DATA_W-1:CNT_W];
         if (init_ok) begin
            init_lo_q <= wr_data[CNT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         to_q <= 1'b0;
      end else begin
         to_q <= (to_q && !(wr_en && sel.stat1 && wr_data[TO_BIT])) || expire_first;
      end
   end

   assign stat2_set[0] = expire_again && !nrb_q;
   assign stat2_set[1] = expire_again;

   for (genvar i = 0; i < STAT2_W; i++) begin : g_stat2
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stat2_q[i] <= 1'b0;
         end else begin
            stat2_q[i] <= (stat2_q[i] && !(wr_en && sel.stat2 && wr_data[i])) || stat2_set[i];
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      if (sel.reload) begin
         rd_mux[CNT_W-1:0] = count;
      end
      if (sel.stat1) begin
         rd_mux[TO_BIT] = to_q;
      end
      if (sel.stat2) begin
         rd_mux[STAT2_W-1:0] = stat2_q;
      end
      if (sel.ctrl1) begin
         rd_mux[HALT_BIT] = halt_q;
      end
      if (sel.ctrl2) begin
         rd_mux[NRB_BIT] = nrb_q;
      end
      if (sel.init) begin
         rd_mux = {init_hi_q, init_lo_q};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en) begin
         rd_q <= rd_mux;
      end
   end

   assign halt      = halt_q;
   assign no_reboot = nrb_q;
   assign timeout_q = to_q;
   assign init_val  = init_lo_q;
   assign rd_data   = rd_q;

endmodule

// File: rtl/sysmgmt_wdog.sv
module sysmgmt_wdog
   import wdog_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 10,
   parameter int MIN_INIT = 4,
   parameter int HALT_BIT = 11,
   parameter int TO_BIT   = 3,
   parameter int NRB_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tick_en,
   output logic              timeout_sts,
   output logic              reset_req
);

   if (CNT_W >= DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must be narrower than DATA_W");
   end
   if (HALT_BIT >= DATA_W || TO_BIT >= DATA_W || NRB_BIT >= DATA_W) begin : g_bad_bit
      $error("control or status bit index outside the data word");
   end
   if (MIN_INIT < 2 || MIN_INIT >= (1 << CNT_W)) begin : g_bad_min
      $error("MIN_INIT must be at least 2 and fit in CNT_W bits");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must cover the 32-byte window");
   end

   wdog_sel_t        sel;
   logic             halt_w;
   logic             nrb_w;
   logic             to_w;
   logic [CNT_W-1:0] init_w;
   logic [CNT_W-1:0] count_w;
   logic             exp_first_w;
   logic             exp_again_w;

   wdog_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .sel  (sel)
   );

   wdog_count #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en      (tick_en),
      .halt         (halt_w),
      .reload       (wr_en && sel.reload),
      .init_val     (init_w),
      .timeout_q    (to_w),
      .no_reboot    (nrb_w),
      .count        (count_w),
      .expire_first (exp_first_w),
      .expire_again (exp_again_w),
      .reset_req    (reset_req)
   );

   wdog_regs #(
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .MIN_INIT (MIN_INIT),
      .HALT_BIT (HALT_BIT),
      .TO_BIT   (TO_BIT),
      .NRB_BIT  (NRB_BIT)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel          (sel),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_en        (rd_en),
      .count        (count_w),
      .expire_first (exp_first_w),
      .expire_again (exp_again_w),
      .halt         (halt_w),
      .no_reboot    (nrb_w),
      .timeout_q    (to_w),
      .init_val     (init_w),
      .rd_data      (rd_data)
   );

   assign timeout_sts = to_w;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
   parameter int ADDR_W   = 5,
   parameter int CNT_W    = 10,
   parameter int MIN_INIT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              reset_req,
   input logic              halt,
   input logic              no_reboot,
   input logic              timeout,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  init_lo
);

   // R6: request lasts a single cycle
   a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   // R6: request only follows an expiry with the timeout flag already set
   a_r6_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(timeout));

   // R7: the gate blocks the request
   a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> !$past(no_reboot));

   // R3: halted count holds unless reloaded
   a_r3_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !(wr_en && addr == ADDR_W'(0))) |=> (count == $past(count)));

   // R4: stored initial value never below the floor
   a_r4_init_floor: assert property (@(posedge clk) disable iff (!rst_n)
      init_lo >= CNT_W'(MIN_INIT));

   // R5: expiry reloads before the count reaches zero
   a_r5_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      count != '0);

endmodule

bind sysmgmt_wdog wdog_chk #(
   .ADDR_W   (ADDR_W),
   .CNT_W    (CNT_W),
   .MIN_INIT (MIN_INIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .wr_en     (wr_en),
   .reset_req (reset_req),
   .halt      (halt_w),
   .no_reboot (nrb_w),
   .timeout   (to_w),
   .count     (count_w),
   .init_lo   (init_w)
);

// File: tb/sim_sysmgmt_wdog.sv
module sim_sysmgmt_wdog;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;
   logic        tick_en = 1'b0;
   logic        timeout_sts;
   logic        reset_req;

   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   sysmgmt_wdog u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (addr),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_en       (rd_en),
      .rd_data     (rd_data),
      .tick_en     (tick_en),
      .timeout_sts (timeout_sts),
      .reset_req   (reset_req)
   );

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [15:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, logic [15:0] exp, string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tk(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_en = 1'b1;
         @(negedge clk);
         tick_en = 1'b0;
      end
   endtask

   // monitor: compares each registered read against the scoreboard queue
   initial begin
      bit fired;
      forever begin
         @(posedge clk);
         fired = rd_en;
         @(negedge clk);
         if (fired) begin
            if (exp_q.size() == 0) begin
               check("R9 unexpected read", rd_data, 16'hxxxx);
            end else begin
               check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 reset_req", {15'd0, reset_req}, 16'd0);
      check("R1 timeout_sts", {15'd0, timeout_sts}, 16'd0);
      rd(5'h00, 16'h0004, "R1 count");
      rd(5'h08, 16'h0800, "R1 halt");
      rd(5'h0A, 16'h0001, "R1 no-reboot");
      rd(5'h12, 16'h0004, "R1 init");
      rd(5'h04, 16'h0000, "R1 stat1");
      rd(5'h06, 16'h0000, "R1 stat2");
      rd(5'h02, 16'h0000, "R9 unmapped");

      // R3 halted after reset
      tk(3);
      rd(5'h00, 16'h0004, "R3 halted count");

      // R4 initial-value filtering
      wr(5'h12, 16'hA410);
      rd(5'h12, 16'hA410, "R4 accept");
      wr(5'h12, 16'hFC02);
      rd(5'h12, 16'hFC10, "R4 reject 2 keeps low");
      wr(5'h12, 16'h0003);
      rd(5'h12, 16'h0010, "R4 reject 3");
      wr(5'h12, 16'h0000);
      rd(5'h12, 16'h0010, "R4 reject 0");
      wr(5'h12, 16'h0004);
      rd(5'h12, 16'h0004, "R4 accept 4");
      wr(5'h12, 16'h0010);

      // R2 reload and readback
      wr(5'h00, 16'h0000);
      rd(5'h00, 16'h0010, "R2 reload");

      // R3 running
      wr(5'h08, 16'h0000);
      rd(5'h08, 16'h0000, "R3 halt readback");
      tk(3);
      rd(5'h00, 16'h000D, "R3 decrement");
      wr(5'h00, 16'h1234);
      rd(5'h00, 16'h0010, "R2 reload mid-count");
      tk(1);
      rd(5'h00, 16'h000F, "R3 one tick");
      wr(5'h08, 16'hFFFF);
      rd(5'h08, 16'h0800, "R3 only halt bit");
      tk(2);
      rd(5'h00, 16'h000F, "R3 frozen");

      // R5 first expiry
      wr(5'h12, 16'h0004);
      wr(5'h00, 16'h0000);
      wr(5'h08, 16'h0000);
      tk(3);
      check("R5 no early timeout", {15'd0, timeout_sts}, 16'd0);
      tk(1);
      check("R5 timeout_sts", {15'd0, timeout_sts}, 16'd1);
      check("R5 no request", {15'd0, reset_req}, 16'd0);
      rd(5'h00, 16'h0004, "R5 reloaded");
      rd(5'h04, 16'h0008, "R5 stat1 bit3");

      // R7 second expiry gated
      tk(4);
      check("R7 gated", {15'd0, reset_req}, 16'd0);
      rd(5'h06, 16'h0002, "R6 second expiry flag");
      wr(5'h06, 16'h0003);
      rd(5'h06, 16'h0000, "R8 clear stat2");

      // R6 reset request
      wr(5'h0A, 16'h0000);
      rd(5'h0A, 16'h0000, "R7 gate readback");
      tk(4);
      check("R6 request high", {15'd0, reset_req}, 16'd1);
      @(negedge clk);
      check("R6 request drops", {15'd0, reset_req}, 16'd0);
      rd(5'h06, 16'h0003, "R6 stat2 both");
      wr(5'h06, 16'h0001);
      rd(5'h06, 16'h0002, "R8 single-bit clear");

      // R8 clear timeout, R5 first expiry again
      wr(5'h04, 16'h0008);
      check("R8 timeout cleared", {15'd0, timeout_sts}, 16'd0);
      tk(4);
      check("R5 re-armed timeout", {15'd0, timeout_sts}, 16'd1);
      check("R5 first expiry no request", {15'd0, reset_req}, 16'd0);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule